// File: doc/BRIEF.md
# Sector ECC Engine Register Front-End

This block is the register-mapped face of a sector error-correction engine that has an encoder channel and a decoder channel. Software drives it over a plain 32-bit bus with separate read and write strobes. Each channel has its own enable word, configuration word, idle flag, interrupt enable and interrupt status. The encoder also holds a direct-input address and a bank of parity result words. The decoder holds per-sector done flags and packed per-sector error counts.

The coding arithmetic is not modelled. A stub engine with a fixed latency per sector stands in for it. When the stub finishes, it fills the parity bank with a deterministic pattern built from the message size, the decoded strength and the word index. It also fills the decoder error counts from the sector index and the strength. Strength is carried as a 5-bit code whose scale is non-linear. Message size is held in bits. A decoder run only counts as complete when the sector expected last has finished.

Top module: `ecc_regfront`

## Requirements
- R1: After reset, every stored register reads 0, both idle words (encoder 0x00C, decoder 0x10C) read 1 in bit 0, and `irq` is 0.
- R2: Encoder config (0x004) keeps only the bits of mask 0x3FFF007F and decoder config (0x104) keeps only the bits of mask 0xBFFF307F. The direct-input address (0x008) keeps all 32 bits. Any address not in the map reads 0.
- R3: Writing a word with bit 0 = 1 to a control register (encoder 0x000, decoder 0x100) starts that channel if it is idle. Its idle bit reads 0 from the next cycle, and bit 0 of the control register reads back the last written value.
- R4: The encoder finishes LATENCY cycles after the clock edge that accepted its start. Decoder sector k finishes (k+1)·LATENCY cycles after that edge. The channel becomes idle again TAIL cycles after its final finish.
- R5: A config write is dropped while its channel is enabled and not idle.
- R6: The strength code sits in config bits 4:0. Codes 0..0x0A mean 4+2·code correctable bits. Codes 0x0B..0x13 mean 28+4·(code−0x0B). Every other code means 4.
- R7: At encoder finish, the parity count becomes ceil(ceil(t·14/8)/4) words. Parity word i (address 0x010+4i) becomes {2'b0, cfg[29:16], t[7:0], i[7:0]} for i below that count, and 0 above it.
- R8: Encoder irq status (0x084 bit 0) sets at finish when its enable (0x080 bit 0) is 1. `irq` is the OR of both channels' status bits. Writing 0 to an enable register clears that channel's status and so drops `irq`.
- R9: The decoder sector count sits in control bits 12:8; 0 means 1 and values above MAX_SECT mean MAX_SECT. Done bit k (0x124) sets when sector k finishes. Decoder irq status (0x204 bit 0) sets only when the last expected sector finishes.
- R10: The error count of decoder sector k is (k+t) mod 64. It sits in bits 5:0 of byte lane k mod 4 of word 0x114+4·(k/4). A start clears all done bits and counts.
- R11: A channel that finishes while its irq enable is 0 leaves its status at 0 and `irq` low.
- R12: A start write to a channel that is already running does not restart it or move its finish time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; data appears after the edge that samples it |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt of both channels |

## Verification
The bench times the interrupt edge exactly against the start edge, and does so again with a second start written mid-run. A design that restarts on that second write, or that counts latency one cycle off, moves the edge and fails. The decoder is run with three sectors, and the bench checks that `irq` is still low when the earlier done bits are already set. A design that completes on any sector's done would raise the interrupt too early. The strength decode is driven at both ends of each linear segment and with an invalid code, and the bench checks the parity word count at its boundary. A wrong segment slope or a missing fallback to 4 shows up as a word that is present where it should be zero, or the reverse. The sector-count clamps (0 and 31) and the clearing of done bits between runs are also exercised, since stale done bits would falsely complete a shorter run.

// File: rtl/ecc_regfront_pkg.sv
// Package: register offsets, field masks and shared types of the ECC
// register front-end. Assumes a 12-bit byte address and 32-bit data.
package ecc_regfront_pkg;

    localparam int ADDR_W = 12;
    localparam int PAR_BITS_PER_T = 14;

    localparam logic [ADDR_W-1:0] A_ENC_CTL  = 12'h000;
    localparam logic [ADDR_W-1:0] A_ENC_CFG  = 12'h004;
    localparam logic [ADDR_W-1:0] A_ENC_DIA  = 12'h008;
    localparam logic [ADDR_W-1:0] A_ENC_IDLE = 12'h00C;
    localparam logic [ADDR_W-1:0] A_PAR_BASE = 12'h010;
    localparam logic [ADDR_W-1:0] A_ENC_IEN  = 12'h080;
    localparam logic [ADDR_W-1:0] A_ENC_STA  = 12'h084;
    localparam logic [ADDR_W-1:0] A_DEC_CTL  = 12'h100;
    localparam logic [ADDR_W-1:0] A_DEC_CFG  = 12'h104;
    localparam logic [ADDR_W-1:0] A_DEC_IDLE = 12'h10C;
    localparam logic [ADDR_W-1:0] A_ERR_BASE = 12'h114;
    localparam logic [ADDR_W-1:0] A_DEC_DONE = 12'h124;
    localparam logic [ADDR_W-1:0] A_DEC_IEN  = 12'h200;
    localparam logic [ADDR_W-1:0] A_DEC_STA  = 12'h204;

    localparam logic [31:0] ENC_CFG_MASK = 32'h3FFF_007F;
    localparam logic [31:0] DEC_CFG_MASK = 32'hBFFF_307F;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_TAIL = 2'd2
    } chan_state_t;

endpackage

// File: rtl/ecc_stub_chan.sv
// Stub engine for one channel. A start pulse runs a number of sectors, each
// LATENCY cycles long. A pulse marks each sector's finish and another marks
// the final one. The channel is idle again TAIL cycles later.
// Assumes LATENCY >= 1 and TAIL >= 1; start is only honoured while idle.
module ecc_stub_chan
    import ecc_regfront_pkg::*;
#(
    parameter int LATENCY  = 8,
    parameter int TAIL     = 3,
    parameter int MAX_SECT = 16,
    localparam int SECT_W  = $clog2(MAX_SECT + 1),
    localparam int CNT_MAX = (LATENCY > TAIL) ? LATENCY : TAIL,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SECT_W-1:0] nsect,
    output logic              idle,
    output logic              sect_done,
    output logic [SECT_W-1:0] sect_idx,
    output logic              last_done
);

    chan_state_t       st;
    logic [CNT_W-1:0]  cnt;
    logic [SECT_W-1:0] sect;
    logic [SECT_W-1:0] total;

    // Decode the finish pulses and the idle flag from the state.
    always_comb begin
        idle      = (st == CH_IDLE);
        sect_done = (st == CH_RUN) && (cnt == CNT_W'(LATENCY - 1));
        last_done = sect_done && (sect == total - SECT_W'(1));
        sect_idx  = sect;
    end

    // Walk the sectors, then the idle-return tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= CH_IDLE;
            cnt   <= '0;
            sect  <= '0;
            total <= '0;
        end else begin
            case (st)
                CH_IDLE: if (start) begin
                    st    <= CH_RUN;
                    cnt   <= '0;
                    sect  <= '0;
                    total <= nsect;
                end
                CH_RUN: begin
                    if (sect_done) begin
                        cnt <= '0;
                        if (last_done) st <= CH_TAIL;
                        else sect <= sect + SECT_W'(1);
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                CH_TAIL: begin
                    if (cnt == CNT_W'(TAIL - 1)) st <= CH_IDLE;
                    else cnt <= cnt + CNT_W'(1);
                end
                default: st <= CH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ecc_strength_dec.sv
// Turns the 5-bit strength code into the correctable-bit count and the
// number of 32-bit parity words it needs. Purely combinational.
// Assumes 14 parity bits per correctable bit.
module ecc_strength_dec
    import ecc_regfront_pkg::*;
#(
    parameter int NW_W = 5
) (
    input  logic [4:0]      code,
    output logic [7:0]      t,
    output logic [NW_W-1:0] nwords
);

    logic [15:0] nbits;
    logic [15:0] nbytes;

    // Map the code onto its two linear segments, with a fallback to 4.
    always_comb begin
        if (code <= 5'd10)
            t = 8'(32'd4 + 32'd2 * 32'(code));
        else if (code <= 5'd19)
            t = 8'(32'd28 + 32'd4 * (32'(code) - 32'd11));
        else
            t = 8'd4;
    end

    // Round the parity length up to bytes, then to whole words.
    always_comb begin
        nbits  = 16'(t) * 16'(PAR_BITS_PER_T);
        nbytes = (nbits + 16'd7) >> 3;
        nwords = NW_W'((nbytes + 16'd3) >> 2);
    end

endmodule

// File: rtl/ecc_parity_bank.sv
// Parity result bank. On fill, every slot below nwords takes a pattern made
// of the message size, the strength and its own index; every other slot
// takes zero. Reads are combinational by slot index.
module ecc_parity_bank #(
    parameter int SLOTS = 28,
    parameter int MSG_W = 14,
    parameter int NW_W  = 5,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill,
    input  logic [MSG_W-1:0] msg_bits,
    input  logic [7:0]       t,
    input  logic [NW_W-1:0]  nwords,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word
);

    logic [SLOTS-1:0][31:0] words;
    logic [SLOTS-1:0][31:0] fill_val;

    // Per-slot fill pattern.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign fill_val[g] = (NW_W'(g) < nwords) ?
                             {16'(msg_bits), t, 8'(g)} : 32'h0;
    end

    // Capture the whole bank when the encoder finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) words <= '0;
        else if (fill) words <= fill_val;
    end

    // Slot read-out, zero beyond the bank.
    always_comb begin
        rd_word = (32'(rd_idx) < SLOTS) ? words[rd_idx] : 32'h0;
    end

endmodule

// File: rtl/ecc_regfront.sv
// Register front-end of a sector ECC engine: encoder and decoder channels,
// each with control, config, idle, irq enable and irq status; encoder parity
// bank and direct-input address; decoder done flags and error counts.
// Assumes a single-cycle write strobe and one bus access per cycle.
module ecc_regfront
    import ecc_regfront_pkg::*;
#(
    parameter int LATENCY   = 8,
    parameter int TAIL      = 3,
    parameter int MAX_SECT  = 16,
    parameter int PAR_SLOTS = 28,
    parameter int MSG_W     = 14,
    localparam int SECT_W    = $clog2(MAX_SECT + 1),
    localparam int PIDX_W    = $clog2(PAR_SLOTS),
    localparam int NW_W      = $clog2(PAR_SLOTS + 1),
    localparam int ERR_WORDS = (MAX_SECT + 3) / 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    logic        enc_en, dec_en;
    logic [31:0] enc_cfg, dec_cfg, enc_dia;
    logic        enc_ien, dec_ien, enc_sta, dec_sta;
    logic [4:0]  dec_nsect_f;
    logic [MAX_SECT-1:0]      dec_done;
    logic [MAX_SECT-1:0][5:0] dec_err;

    logic              enc_idle, dec_idle;
    logic              enc_sdone, enc_last, dec_sdone, dec_last;
    logic [SECT_W-1:0] enc_sidx, dec_sidx, dec_nsect;
    logic              enc_start, dec_start;
    logic [7:0]        enc_t, dec_t;
    logic [NW_W-1:0]   enc_nw, dec_nw;
    logic [PIDX_W-1:0] par_idx;
    logic [31:0]       par_word;
    logic [ERR_WORDS-1:0][31:0] err_words;
    logic [11:0]       par_off, err_off;
    logic              par_hit, err_hit;
    logic [31:0]       rd_val;

    // Decode start requests and the clamped decoder sector count.
    always_comb begin
        enc_start = bus_wr && (bus_addr == A_ENC_CTL) && bus_wdata[0] && enc_idle;
        dec_start = bus_wr && (bus_addr == A_DEC_CTL) && bus_wdata[0] && dec_idle;
        if (bus_wr && bus_addr == A_DEC_CTL) begin
            if (bus_wdata[12:8] == 5'd0) dec_nsect = SECT_W'(1);
            else if (32'(bus_wdata[12:8]) > MAX_SECT) dec_nsect = SECT_W'(MAX_SECT);
            else dec_nsect = SECT_W'(bus_wdata[12:8]);
        end else begin
            dec_nsect = SECT_W'(1);
        end
    end

    ecc_stub_chan #(.LATENCY(LATENCY), .TAIL(TAIL), .MAX_SECT(MAX_SECT)) u_enc_chan (
        .clk(clk), .rst_n(rst_n), .start(enc_start), .nsect(SECT_W'(1)),
        .idle(enc_idle), .sect_done(enc_sdone), .sect_idx(enc_sidx),
        .last_done(enc_last)
    );

    ecc_stub_chan #(.LATENCY(LATENCY), .TAIL(TAIL), .MAX_SECT(MAX_SECT)) u_dec_chan (
        .clk(clk), .rst_n(rst_n), .start(dec_start), .nsect(dec_nsect),
        .idle(dec_idle), .sect_done(dec_sdone), .sect_idx(dec_sidx),
        .last_done(dec_last)
    );

    ecc_strength_dec #(.NW_W(NW_W)) u_enc_str (
        .code(enc_cfg[4:0]), .t(enc_t), .nwords(enc_nw)
    );

    ecc_strength_dec #(.NW_W(NW_W)) u_dec_str (
        .code(dec_cfg[4:0]), .t(dec_t), .nwords(dec_nw)
    );

    ecc_parity_bank #(.SLOTS(PAR_SLOTS), .MSG_W(MSG_W), .NW_W(NW_W)) u_par (
        .clk(clk), .rst_n(rst_n), .fill(enc_last),
        .msg_bits(enc_cfg[16 +: MSG_W]), .t(enc_t), .nwords(enc_nw),
        .rd_idx(par_idx), .rd_word(par_word)
    );

    // Encoder control, config, address and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_en  <= 1'b0;
            enc_cfg <= '0;
            enc_dia <= '0;
            enc_ien <= 1'b0;
            enc_sta <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_ENC_CTL) enc_en <= bus_wdata[0];
            if (bus_wr && bus_addr == A_ENC_CFG && !(enc_en && !enc_idle))
                enc_cfg <= bus_wdata & ENC_CFG_MASK;
            if (bus_wr && bus_addr == A_ENC_DIA) enc_dia <= bus_wdata;
            if (bus_wr && bus_addr == A_ENC_IEN) enc_ien <= bus_wdata[0];
            if (bus_wr && bus_addr == A_ENC_IEN && !bus_wdata[0]) enc_sta <= 1'b0;
            else if (enc_last && enc_ien) enc_sta <= 1'b1;
        end
    end

    // Decoder control, config and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_en      <= 1'b0;
            dec_nsect_f <= '0;
            dec_cfg     <= '0;
            dec_ien     <= 1'b0;
            dec_sta     <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_DEC_CTL) begin
                dec_en      <= bus_wdata[0];
                dec_nsect_f <= bus_wdata[12:8];
            end
            if (bus_wr && bus_addr == A_DEC_CFG && !(dec_en && !dec_idle))
                dec_cfg <= bus_wdata & DEC_CFG_MASK;
            if (bus_wr && bus_addr == A_DEC_IEN) dec_ien <= bus_wdata[0];
            if (bus_wr && bus_addr == A_DEC_IEN && !bus_wdata[0]) dec_sta <= 1'b0;
            else if (dec_last && dec_ien) dec_sta <= 1'b1;
        end
    end

    // Per-sector done flags and error counts, cleared by a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_done <= '0;
            dec_err  <= '0;
        end else if (dec_start) begin
            dec_done <= '0;
            dec_err  <= '0;
        end else if (dec_sdone) begin
            dec_done[dec_sidx] <= 1'b1;
            dec_err[dec_sidx]  <= 6'(32'(dec_sidx) + 32'(dec_t));
        end
    end

    // Pack four sector counts per word, one per byte lane.
    for (genvar w = 0; w < ERR_WORDS; w++) begin : g_errw
        for (genvar l = 0; l < 4; l++) begin : g_lane
            if (4 * w + l < MAX_SECT) begin : g_used
                assign err_words[w][8*l +: 8] = {2'b00, dec_err[4*w + l]};
            end else begin : g_pad
                assign err_words[w][8*l +: 8] = 8'h00;
            end
        end
    end

    // Locate the parity and error-count windows.
    always_comb begin
        par_off = bus_addr - A_PAR_BASE;
        err_off = bus_addr - A_ERR_BASE;
        par_hit = (bus_addr >= A_PAR_BASE) && (32'(par_off) < 4 * PAR_SLOTS)
                  && (bus_addr[1:0] == 2'b00);
        err_hit = (bus_addr >= A_ERR_BASE) && (32'(err_off) < 4 * ERR_WORDS)
                  && (bus_addr[1:0] == 2'b00);
        par_idx = PIDX_W'(par_off >> 2);
    end

    // Read multiplexer.
    always_comb begin
        rd_val = 32'h0;
        if (par_hit) rd_val = par_word;
        else if (err_hit) rd_val = err_words[err_off >> 2];
        else begin
            case (bus_addr)
                A_ENC_CTL:  rd_val = {31'b0, enc_en};
                A_ENC_CFG:  rd_val = enc_cfg;
                A_ENC_DIA:  rd_val = enc_dia;
                A_ENC_IDLE: rd_val = {31'b0, enc_idle};
                A_ENC_IEN:  rd_val = {31'b0, enc_ien};
                A_ENC_STA:  rd_val = {31'b0, enc_sta};
                A_DEC_CTL:  rd_val = {19'b0, dec_nsect_f, 7'b0, dec_en};
                A_DEC_CFG:  rd_val = dec_cfg;
                A_DEC_IDLE: rd_val = {31'b0, dec_idle};
                A_DEC_DONE: rd_val = 32'(dec_done);
                A_DEC_IEN:  rd_val = {31'b0, dec_ien};
                A_DEC_STA:  rd_val = {31'b0, dec_sta};
                default:    rd_val = 32'h0;
            endcase
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // Combined interrupt.
    always_comb irq = enc_sta || dec_sta;

endmodule

// File: rtl/ecc_regfront_chk.sv
// Checker for ecc_regfront: config lock, start behaviour, interrupt clear
// and decoder completion gating. Attached by the bind below.
module ecc_regfront_chk
    import ecc_regfront_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        enc_en,
    input logic        enc_idle,
    input logic [31:0] enc_cfg,
    input logic        dec_en,
    input logic        dec_idle,
    input logic [31:0] dec_cfg,
    input logic        enc_sta,
    input logic        dec_sta,
    input logic        dec_last
);

    a_r5_enc_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_en && !enc_idle) |=> $stable(enc_cfg));

    a_r5_dec_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !dec_idle) |=> $stable(dec_cfg));

    a_r3_start_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENC_CTL && bus_wdata[0] && enc_idle) |=> !enc_idle);

    a_r8_ien_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENC_IEN && !bus_wdata[0]) |=> !enc_sta);

    a_r9_dec_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_sta) |-> $past(dec_last));

endmodule

bind ecc_regfront ecc_regfront_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .enc_en(enc_en), .enc_idle(enc_idle),
    .enc_cfg(enc_cfg), .dec_en(dec_en), .dec_idle(dec_idle),
    .dec_cfg(dec_cfg), .enc_sta(enc_sta), .dec_sta(dec_sta),
    .dec_last(dec_last)
);

// File: tb/ecc_regfront_test.sv
// Directed bench for ecc_regfront: one task per scenario.
module ecc_regfront_test;

    localparam int LAT = 8;
    localparam int TL  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    ecc_regfront #(.LATENCY(LAT), .TAIL(TL)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] exp_t(input logic [4:0] c);
        if (c <= 10) return 8'(4 + 2 * c);
        if (c <= 19) return 8'(28 + 4 * (c - 11));
        return 8'd4;
    endfunction

    function automatic int exp_nw(input logic [7:0] t);
        int nbytes = (t * 14 + 7) / 8;
        return (nbytes + 3) / 4;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        #1 bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_idle(input logic [11:0] a);
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(a, v);
            if (v[0]) return;
        end
    endtask

    // R1: reset values.
    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 0);
        rd(12'h00C, v); chk("R1 enc idle", v, 1);
        rd(12'h10C, v); chk("R1 dec idle", v, 1);
        rd(12'h000, v); chk("R1 enc ctl", v, 0);
        rd(12'h010, v); chk("R1 parity0", v, 0);
        rd(12'h124, v); chk("R1 dec done", v, 0);
    endtask

    // R2: masks, full-width address, unmapped reads.
    task automatic t_readback();
        logic [31:0] v;
        wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, v); chk("R2 enc cfg mask", v, 32'h3FFF_007F);
        wr(12'h104, 32'hFFFF_FFFF); rd(12'h104, v); chk("R2 dec cfg mask", v, 32'hBFFF_307F);
        wr(12'h008, 32'h1234_5678); rd(12'h008, v); chk("R2 dia", v, 32'h1234_5678);
        rd(12'h300, v); chk("R2 unmapped", v, 0);
        rd(12'h110, v); chk("R2 hole", v, 0);
    endtask

    // R6/R7: strength decode and parity word count at its boundary.
    task automatic t_strength(input logic [4:0] code);
        logic [31:0] v;
        logic [13:0] msg = 14'h0100 + 14'(code);
        logic [7:0]  t = exp_t(code);
        int nw = exp_nw(t);
        wr(12'h004, {2'b0, msg, 9'b0, 2'b01, code});
        wr(12'h000, 1);
        wait_idle(12'h00C);
        wr(12'h000, 0);
        rd(12'h010 + 12'(4 * (nw - 1)), v);
        chk("R6 R7 last parity word", v, {2'b0, msg, t, 8'(nw - 1)});
        if (nw < 28) begin
            rd(12'h010 + 12'(4 * nw), v);
            chk("R7 word past count", v, 0);
        end
    endtask

    // R3/R4/R8/R12: start, exact irq timing with a mid-run start write, clear.
    task automatic t_enc_irq();
        logic [31:0] v;
        wr(12'h080, 1);
        wr(12'h000, 1);
        wr(12'h000, 1);
        repeat (LAT - 2) @(posedge clk);
        #1 chk("R4 R12 irq before finish", {31'b0, irq}, 0);
        @(posedge clk);
        #1 chk("R4 R8 irq at finish", {31'b0, irq}, 1);
        rd(12'h084, v); chk("R8 enc status", v, 1);
        rd(12'h00C, v); chk("R4 not idle during tail", v, 0);
        rd(12'h000, v); chk("R3 ctl readback", v, 1);
        wr(12'h080, 0);
        #1 chk("R8 irq cleared", {31'b0, irq}, 0);
        rd(12'h084, v); chk("R8 status cleared", v, 0);
        wait_idle(12'h00C);
        wr(12'h000, 0);
    endtask

    // R3/R5: start drops idle; config locked while running.
    task automatic t_lock();
        logic [31:0] v;
        wr(12'h004, 32'h0040_0002);
        wr(12'h000, 1);
        rd(12'h00C, v); chk("R3 idle low after start", v, 0);
        wr(12'h004, 32'h0080_0005);
        rd(12'h004, v); chk("R5 cfg locked", v, 32'h0040_0002);
        wait_idle(12'h00C);
        wr(12'h004, 32'h0080_0005);
        rd(12'h004, v); chk("R5 cfg free when idle", v, 32'h0080_0005);
        wr(12'h000, 0);
    endtask

    // R11: finish with irq disabled.
    task automatic t_ien_off();
        logic [31:0] v;
        wr(12'h000, 1);
        wait_idle(12'h00C);
        rd(12'h084, v); chk("R11 status stays 0", v, 0);
        chk("R11 irq low", {31'b0, irq}, 0);
        wr(12'h000, 0);
    endtask

    // R9/R10: three-sector decode, completion gated on the last sector.
    task automatic t_dec3();
        logic [31:0] v;
        wr(12'h104, 32'h8000_3002);
        wr(12'h200, 1);
        wr(12'h100, 32'h0000_0301);
        repeat (3 * LAT - 1) @(posedge clk);
        #1 chk("R9 irq held until last sector", {31'b0, irq}, 0);
        @(posedge clk);
        #1 chk("R9 irq at last sector", {31'b0, irq}, 1);
        rd(12'h124, v); chk("R9 done bits", v, 32'h7);
        rd(12'h114, v); chk("R10 err word0", v, 32'h000A_0908);
        rd(12'h118, v); chk("R10 err word1", v, 0);
        rd(12'h100, v); chk("R9 ctl readback", v, 32'h0000_0301);
        wr(12'h200, 0);
        wait_idle(12'h10C);
        wr(12'h100, 0);
    endtask

    // R9/R10: count 0 means one sector; start clears stale done bits.
    task automatic t_dec_zero();
        logic [31:0] v;
        wr(12'h200, 1);
        wr(12'h100, 32'h0000_0001);
        repeat (LAT - 1) @(posedge clk);
        #1 chk("R9 count0 irq early", {31'b0, irq}, 0);
        @(posedge clk);
        #1 chk("R9 count0 irq", {31'b0, irq}, 1);
        rd(12'h124, v); chk("R10 done cleared by start", v, 32'h1);
        wr(12'h200, 0);
        wait_idle(12'h10C);
        wr(12'h100, 0);
    endtask

    // R9/R10: count 31 clamps to sixteen sectors.
    task automatic t_dec_clamp();
        logic [31:0] v;
        wr(12'h100, 32'h0000_1F01);
        wait_idle(12'h10C);
        rd(12'h124, v); chk("R9 clamp done bits", v, 32'hFFFF);
        rd(12'h120, v); chk("R10 err word3", v, 32'h1716_1514);
        wr(12'h100, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_readback();
        t_strength(5'h00);
        t_strength(5'h01);
        t_strength(5'h0A);
        t_strength(5'h0B);
        t_strength(5'h13);
        t_strength(5'h1F);
        t_lock();
        t_enc_irq();
        t_ien_off();
        t_dec3();
        t_dec_zero();
        t_dec_clamp();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule